// File: doc/BRIEF.md
# Single-Cycle Register/Memory Execute Datapath

This block is the execute half of a single-cycle 32-bit integer processor. Every clock cycle it takes one instruction word and a set of already-decoded control pins. It reads two source registers and runs the ALU. It may read or write a word-addressed data memory. On the rising edge it may write one result back to the register file. It covers register-to-register arithmetic and logic (add, subtract, and, or, set-less-than), word loads and word stores. Three selectors resolve the conflicts between these instruction classes:
- The destination-register selector takes rd or rt.
- The ALU right-operand selector takes rt data or the sign-extended immediate.
- The write-back selector takes the ALU result or the memory data.

Instruction fetch, next-PC selection and control decoding belong to neighbouring blocks. The ALU zero flag is driven out so that a branch unit can compare two registers. The datapath has no flow control. One instruction is consumed per clock with no stall or back-pressure, so the pins are plain level signals. A separate preload port lets the environment place words in data memory before or between instructions.

Top module: `sc_exec_datapath`

## Requirements
- R1: The first register operand is read from the register numbered by instruction bits 25:21. The second register operand is read from the register numbered by bits 20:16.
- R2: The destination register is instruction bits 15:11 when `reg_dst`=1, and bits 20:16 when `reg_dst`=0.
- R3: With `alu_src`=1, the ALU right operand is instruction bits 15:0 sign-extended to 32 bits. With `alu_src`=0, it is the second register operand.
- R4: Register write data (`wb_data`) is the data memory read value when `mem_to_reg`=1, and the ALU result when `mem_to_reg`=0.
- R5: A register is updated on the rising clock edge only when `reg_write`=1. Register 0 always reads as zero, and writes to it are discarded. Reads are combinational.
- R6: When `mem_write`=1, the second register operand is written on the rising edge to the data memory word whose index is ALU result bits [AW+1:2]. With `mem_write`=0, memory is left unchanged.
- R7: `alu_op` selects the operation: 3'b010 add, 3'b110 subtract, 3'b000 and, 3'b001 or, 3'b111 set-less-than.
- R8: Set-less-than gives 1 in bit 0 when the left operand is below the right operand under signed comparison, and gives 0 otherwise. Bits 31:1 are always zero.
- R9: `zero` is 1 exactly when the ALU result is all zeros.
- R10: An active-low `rst_n` clears every register to zero.
- R11: `pl_we`=1 writes `pl_data` to memory word `pl_addr` on the rising edge. If a store hits the same cycle, the preload wins.
- R12: The data memory read value is the addressed word when `mem_read`=1, and zero when `mem_read`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| instr | input | 32 | Instruction word of the current cycle |
| reg_dst | input | 1 | Destination select: 1 = rd field, 0 = rt field |
| alu_src | input | 1 | ALU right operand select: 1 = immediate, 0 = register |
| mem_to_reg | input | 1 | Write-back select: 1 = memory, 0 = ALU |
| reg_write | input | 1 | Register file write enable |
| mem_read | input | 1 | Data memory read enable |
| mem_write | input | 1 | Data memory store enable |
| alu_op | input | 3 | ALU operation selector |
| pl_we | input | 1 | Memory preload write enable |
| pl_addr | input | 6 | Memory preload word index |
| pl_data | input | 32 | Memory preload data |
| alu_result | output | 32 | ALU result (also the memory byte address) |
| zero | output | 1 | ALU result is zero |
| wb_data | output | 32 | Value presented to the register file write port |

## Verification
The hardest behaviour to reach from the ports is a register or memory word that must stay unchanged. A write that was disabled, or a write to register 0, shows nothing on its own. The stimulus therefore follows each such attempt with an instruction whose only job is to move the protected location onto `alu_result` or `wb_data`. For a register this is an add with register 0. For a memory word it is a load. The same method covers a store that collides with a preload: a load of the contested word shows which writer won. Signed set-less-than is driven with operands whose signed and unsigned orders differ, so an unsigned comparator would give the wrong answer.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_hard_zero
      assign regs[g] = '0;
    end else begin : g_storage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (we && (waddr == AW'(g)))
          regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int unsigned W = 32
) (
  input  dp_pkg::alu_op_e op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y,
  output logic            zero
);
  import dp_pkg::*;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/dp_dmem.sv
module dp_dmem #(
  parameter int unsigned W     = 32,
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          st_en,
  input  logic [AW-1:0] st_idx,
  input  logic [W-1:0]  st_data,
  input  logic          pl_en,
  input  logic [AW-1:0] pl_idx,
  input  logic [W-1:0]  pl_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (pl_en)
      mem[pl_idx] <= pl_data;
    else if (st_en)
      mem[st_idx] <= st_data;
  end

  assign rd_data = rd_en ? mem[rd_idx] : '0;
endmodule

// File: rtl/sc_exec_datapath.sv
module sc_exec_datapath #(
  parameter int unsigned W         = 32,
  parameter int unsigned NREG      = 32,
  parameter int unsigned MEM_WORDS = 64,
  localparam int unsigned RAW      = $clog2(NREG),
  localparam int unsigned MAW      = $clog2(MEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    instr,
  input  logic           reg_dst,
  input  logic           alu_src,
  input  logic           mem_to_reg,
  input  logic           reg_write,
  input  logic           mem_read,
  input  logic           mem_write,
  input  logic [2:0]     alu_op,
  input  logic           pl_we,
  input  logic [MAW-1:0] pl_addr,
  input  logic [W-1:0]   pl_data,
  output logic [W-1:0]   alu_result,
  output logic           zero,
  output logic [W-1:0]   wb_data
);
  import dp_pkg::*;

  // instruction fields
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [15:0]    f_imm;
  logic [5:0]     unused_opcode;

  assign f_rs          = instr[21 +: RAW];
  assign f_rt          = instr[16 +: RAW];
  assign f_rd          = instr[11 +: RAW];
  assign f_imm         = instr[15:0];
  assign unused_opcode = instr[31:26];

  logic [W-1:0]   rs_data, rt_data, imm_ext, alu_b, mem_rdata;
  logic [RAW-1:0] wr_addr;
  logic [MAW-1:0] dmem_idx;

  // selector 1: destination register
  assign wr_addr = reg_dst ? f_rd : f_rt;

  // sign extension and selector 2: ALU right operand
  assign imm_ext = {{(W-16){f_imm[15]}}, f_imm};
  assign alu_b   = alu_src ? imm_ext : rt_data;

  dp_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_write),
    .waddr   (wr_addr),
    .wdata   (wb_data),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .rdata_a (rs_data),
    .rdata_b (rt_data)
  );

  dp_alu #(.W(W)) u_alu (
    .op   (alu_op_e'(alu_op)),
    .a    (rs_data),
    .b    (alu_b),
    .y    (alu_result),
    .zero (zero)
  );

  assign dmem_idx = alu_result[MAW+1:2];

  dp_dmem #(.W(W), .WORDS(MEM_WORDS)) u_mem (
    .clk     (clk),
    .st_en   (mem_write),
    .st_idx  (dmem_idx),
    .st_data (rt_data),
    .pl_en   (pl_we),
    .pl_idx  (pl_addr),
    .pl_data (pl_data),
    .rd_en   (mem_read),
    .rd_idx  (dmem_idx),
    .rd_data (mem_rdata)
  );

  // selector 3: write-back source
  assign wb_data = mem_to_reg ? mem_rdata : alu_result;
endmodule

// File: rtl/sc_exec_datapath_chk.sv
module sc_exec_datapath_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned RAW = 5,
  parameter int unsigned MAW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [31:0]    instr,
  input logic           reg_write,
  input logic [RAW-1:0] wr_addr,
  input logic [W-1:0]   wb_data,
  input logic [W-1:0]   rs_data,
  input logic [W-1:0]   rt_data,
  input logic [W-1:0]   alu_b,
  input logic [2:0]     alu_op,
  input logic [W-1:0]   alu_result,
  input logic           zero,
  input logic           mem_write,
  input logic           mem_read,
  input logic           pl_we,
  input logic [MAW-1:0] pl_addr,
  input logic [W-1:0]   pl_data,
  input logic [MAW-1:0] dmem_idx,
  input logic [W-1:0]   mem_rdata
);
  AST_REG_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_write) && ($past(wr_addr) != '0) && (instr[21 +: RAW] == $past(wr_addr)))
      |-> (rs_data == $past(wb_data))); // R5

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[21 +: RAW] == '0) |-> (rs_data == '0)); // R5

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mem_write && !pl_we) && mem_read && (dmem_idx == $past(dmem_idx)))
      |-> (mem_rdata == $past(rt_data))); // R6

  AST_PRELOAD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pl_we) && mem_read && (dmem_idx == $past(pl_addr)))
      |-> (mem_rdata == $past(pl_data))); // R11

  AST_SUB_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((alu_op == 3'b110) && (rs_data == alu_b)) |-> zero); // R9

  AST_SLT_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'b111) |-> (alu_result[W-1:1] == '0)); // R8

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_read |-> (mem_rdata == '0)); // R12
endmodule

bind sc_exec_datapath sc_exec_datapath_chk #(.W(W), .RAW(RAW), .MAW(MAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .reg_write  (reg_write),
  .wr_addr    (wr_addr),
  .wb_data    (wb_data),
  .rs_data    (rs_data),
  .rt_data    (rt_data),
  .alu_b      (alu_b),
  .alu_op     (alu_op),
  .alu_result (alu_result),
  .zero       (zero),
  .mem_write  (mem_write),
  .mem_read   (mem_read),
  .pl_we      (pl_we),
  .pl_addr    (pl_addr),
  .pl_data    (pl_data),
  .dmem_idx   (dmem_idx),
  .mem_rdata  (mem_rdata)
);

// File: tb/tb_sc_exec_datapath.sv
module tb_sc_exec_datapath;
  localparam time TCLK = 10ns;

  localparam logic [2:0] OP_AND = 3'b000, OP_OR = 3'b001, OP_ADD = 3'b010,
                         OP_SUB = 3'b110, OP_SLT = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        reg_dst = 0, alu_src = 0, mem_to_reg = 0, reg_write = 0;
  logic        mem_read = 0, mem_write = 0;
  logic [2:0]  alu_op = OP_ADD;
  logic        pl_we = 0;
  logic [5:0]  pl_addr = '0;
  logic [31:0] pl_data = '0;
  logic [31:0] alu_result, wb_data;
  logic        zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       tag;
    logic [31:0] exp_res;
    logic        exp_zero;
    logic [31:0] exp_wb;
  } item_t;

  item_t sb_q[$];

  always #(TCLK/2) clk = ~clk;

  sc_exec_datapath dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .reg_dst(reg_dst), .alu_src(alu_src),
    .mem_to_reg(mem_to_reg), .reg_write(reg_write), .mem_read(mem_read),
    .mem_write(mem_write), .alu_op(alu_op), .pl_we(pl_we), .pl_addr(pl_addr),
    .pl_data(pl_data), .alu_result(alu_result), .zero(zero), .wb_data(wb_data)
  );

  function automatic logic [31:0] rins(input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction

  function automatic logic [31:0] iins(input int rs, input int rt, input logic [15:0] imm);
    return {6'h23, 5'(rs), 5'(rt), imm};
  endfunction

  // driver: applies one instruction at a falling edge and queues its expectation
  task automatic exec(input logic [31:0] ins, input logic rdst, input logic asrc,
                      input logic m2r, input logic rw, input logic mr, input logic mw,
                      input logic [2:0] op, input string tag, input logic [31:0] eres,
                      input logic ez, input logic [31:0] ewb,
                      input logic plw = 1'b0, input logic [5:0] pla = '0,
                      input logic [31:0] pld = '0);
    item_t it;
    @(negedge clk);
    instr = ins; reg_dst = rdst; alu_src = asrc; mem_to_reg = m2r;
    reg_write = rw; mem_read = mr; mem_write = mw; alu_op = op;
    pl_we = plw; pl_addr = pla; pl_data = pld;
    it.tag = tag; it.exp_res = eres; it.exp_zero = ez; it.exp_wb = ewb;
    sb_q.push_back(it);
  endtask

  task automatic preload(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    instr = '0; reg_write = 0; mem_write = 0; mem_read = 0;
    pl_we = 1; pl_addr = a; pl_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_write = 0; mem_write = 0; mem_read = 0; pl_we = 0; instr = '0;
  endtask

  // monitor: compares outputs a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(TCLK/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (alu_result !== it.exp_res || zero !== it.exp_zero || wb_data !== it.exp_wb) begin
          fails++;
          $display("FAIL %s: alu=%h zero=%b wb=%h expected alu=%h zero=%b wb=%h",
                   it.tag, alu_result, zero, wb_data, it.exp_res, it.exp_zero, it.exp_wb);
        end
      end
    end
  end

  initial begin
    #(TCLK*20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: registers read zero after reset
    exec(rins(5, 6, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R10 reset regs", 32'h0, 1, 32'h0);

    preload(6'd1, 32'h0000_0010);
    preload(6'd2, 32'hFFFF_FFF0);
    preload(6'd3, 32'h7FFF_FFFF);
    preload(6'd6, 32'hAAAA_5555);
    idle();

    // R4 R2: loads write rt, data from memory
    exec(iins(0, 1, 16'd4), 0, 1, 1, 1, 1, 0, OP_ADD, "R4 lw r1", 32'd4, 0, 32'h10);
    exec(iins(0, 2, 16'd8), 0, 1, 1, 1, 1, 0, OP_ADD, "R4 lw r2", 32'd8, 0, 32'hFFFF_FFF0);
    // R3: negative immediate sign-extended
    exec(iins(1, 3, 16'hFFFC), 0, 1, 1, 1, 1, 0, OP_ADD, "R3 lw neg imm", 32'd12, 0, 32'h7FFF_FFFF);
    // R7 R9 R1: register-register ops
    exec(rins(1, 2, 4), 1, 0, 0, 1, 0, 0, OP_ADD, "R7 add to zero", 32'h0, 1, 32'h0);
    exec(rins(3, 1, 5), 1, 0, 0, 1, 0, 0, OP_SUB, "R7 sub", 32'h7FFF_FFEF, 0, 32'h7FFF_FFEF);
    exec(rins(3, 2, 6), 1, 0, 0, 1, 0, 0, OP_AND, "R7 and", 32'h7FFF_FFF0, 0, 32'h7FFF_FFF0);
    exec(rins(3, 2, 7), 1, 0, 0, 1, 0, 0, OP_OR,  "R7 or", 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF);
    // R8: signed compare
    exec(rins(2, 1, 8), 1, 0, 0, 1, 0, 0, OP_SLT, "R8 slt neg<pos", 32'd1, 0, 32'd1);
    exec(rins(3, 2, 9), 1, 0, 0, 1, 0, 0, OP_SLT, "R8 slt pos<neg", 32'd0, 1, 32'd0);
    // R2 R1: rd path wrote r8, read back through rt field
    exec(rins(0, 8, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R2 rd dest r8", 32'd1, 0, 32'd1);
    exec(rins(7, 0, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R1 rs read r7", 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF);
    // R5: write to r0 ignored
    exec(rins(3, 0, 0), 1, 0, 0, 1, 0, 0, OP_ADD, "R5 write r0", 32'h7FFF_FFFF, 0, 32'h7FFF_FFFF);
    exec(rins(0, 0, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R5 r0 stays zero", 32'h0, 1, 32'h0);
    // R5: reg_write low leaves register untouched
    exec(rins(1, 1, 10), 1, 0, 0, 0, 0, 0, OP_ADD, "R5 no write", 32'd32, 0, 32'd32);
    exec(rins(10, 0, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R5 r10 unchanged", 32'h0, 1, 32'h0);
    // R6: store then load back
    exec(iins(0, 3, 16'd20), 0, 1, 0, 0, 0, 1, OP_ADD, "R6 sw", 32'd20, 0, 32'd20);
    exec(iins(0, 11, 16'd20), 0, 1, 1, 1, 1, 0, OP_ADD, "R6 lw stored", 32'd20, 0, 32'h7FFF_FFFF);
    exec(rins(11, 0, 0), 1, 0, 0, 0, 0, 0, OP_ADD, "R6 r11 value", 32'h7FFF_FFFF, 0, 32'h7FFF_FFFF);
    // R6: mem_write low leaves word intact
    exec(iins(0, 1, 16'd24), 0, 1, 0, 0, 0, 0, OP_ADD, "R6 sw disabled", 32'd24, 0, 32'd24);
    exec(iins(0, 12, 16'd24), 0, 1, 1, 1, 1, 0, OP_ADD, "R6 word kept", 32'd24, 0, 32'hAAAA_5555);
    // R12: mem_read low gives zero
    exec(iins(0, 13, 16'd4), 0, 1, 1, 1, 0, 0, OP_ADD, "R12 no read", 32'd4, 0, 32'h0);
    // R11: preload wins over store
    exec(iins(0, 3, 16'd28), 0, 1, 0, 0, 0, 1, OP_ADD, "R11 collide", 32'd28, 0, 32'd28,
         1'b1, 6'd7, 32'h1234_5678);
    exec(iins(0, 14, 16'd28), 0, 1, 1, 1, 1, 0, OP_ADD, "R11 preload wins", 32'd28, 0, 32'h1234_5678);
    // R9 R8
    exec(rins(1, 1, 15), 1, 0, 0, 1, 0, 0, OP_SUB, "R9 sub equal", 32'h0, 1, 32'h0);
    exec(rins(2, 3, 16), 1, 0, 0, 1, 0, 0, OP_SLT, "R8 slt signed", 32'd1, 0, 32'd1);
    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule